// File: doc/BRIEF.md
# Register-Configured Interrupt Crossbar

This block sits in front of a subsystem interrupt controller with 32 request inputs and decides which request drives each of them. The low eight output lines are remappable. Each is fed by its own selector, which picks one request out of a wide vector of device interrupts using a 9-bit index held in a small control register bank. The upper 24 lines have no selector. Each is either tied to a fixed internal source or held inactive, and no register write can change that wiring.

Software reads and writes the selector fields through a simple word-addressed port. Four 32-bit registers hold the eight fields, two fields packed per word. After reset every selector points at its own default source, so the controller sees a working set of interrupts before software touches the bank. One default source is an external pin that signals active low. It is inverted inside the block, so the controller only ever sees active-high, level-sensitive requests. By default a request travels from input to output with no register on the way. A build option adds one output register stage.

Top module: `irq_xbar_top`

## Requirements
- R1: After reset, selector field n (n = 0..7) holds n+1. Register k (k = 0..3) holds the field of line 2k in bits [8:0] and the field of line 2k+1 in bits [24:16], so register k reads {7'b0, 9'(2k+2), 7'b0, 9'(2k+1)}.
- R2: For output line n in 0..7 whose field holds a value s with 1 <= s <= 419, irq_out[n] equals input request s. Input request s is dev_irq[s], except as stated in R6. The path is combinational.
- R3: A field value of 0, or any value of 420 or above, drives its output line to 0 whatever the inputs.
- R4: Register bits [15:9] and [31:25] always read as 0, and writing ones to them has no effect.
- R5: A write (reg_we high at a rising clock edge) updates both fields of register reg_addr from reg_wdata[8:0] and reg_wdata[24:16]. Reads (reg_rdata, combinational from reg_addr) and routing show the new value only after that edge.
- R6: Input request 2 is the inverse of ext_irq_n, so a low pin gives an active-high request. dev_irq[2] and dev_irq[0] have no effect on any output.
- R7: For j = 0..23, irq_out[8+j] equals fixed_irq[j] AND FIXED_MASK[j]. By default the mask enables lines 9, 17 and 28 only. Register writes never alter these lines.
- R8: With REG_OUT = 1 every output appears exactly one clock cycle later than with REG_OUT = 0, and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_irq | input | 420 | Device interrupt requests, active high, bit s is input index s |
| ext_irq_n | input | 1 | External interrupt pin, active low, presented as input index 2 |
| fixed_irq | input | 24 | Internal sources for output lines 8..31 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_out | output | 32 | Requests to the interrupt controller |

## Verification
A corrupted selector field shows at the ports in two places: on the next readback of its register, and on its output line as soon as the wrong input index and the right one carry different levels. The bench drives distinct patterns on the inputs so that a swapped even/odd field, an off-by-one default or a mis-decoded index changes irq_out in the same cycle. A stale or early register update shows up as a readback mismatch exactly one edge after the write. A leak into the fixed lines appears as soon as a write or a select change moves any bit of irq_out[31:8].

// File: rtl/irq_xbar_pkg.sv
`timescale 1ns/1ps
package irq_xbar_pkg;
    // Width of one selector index field
    localparam int XB_SEL_W = 9;
    // Bit offsets of the even-line and odd-line fields inside one control word
    localparam int XB_LO_OFF = 0;
    localparam int XB_HI_OFF = 16;
    localparam int XB_WORD_W = 32;

    // Mask of the bits of a control word that hold field state
    localparam logic [XB_WORD_W-1:0] XB_FIELD_MASK =
        (XB_WORD_W'((1 << XB_SEL_W) - 1) << XB_LO_OFF) |
        (XB_WORD_W'((1 << XB_SEL_W) - 1) << XB_HI_OFF);
endpackage

// File: rtl/xbar_regs.sv
`timescale 1ns/1ps
module xbar_regs
    import irq_xbar_pkg::*;
#(
    parameter int N_SEL  = 8,
    parameter int SEL_W  = XB_SEL_W,
    parameter int ADDR_W = $clog2(N_SEL / 2)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [XB_WORD_W-1:0]           wdata,
    output logic [XB_WORD_W-1:0]           rdata,
    output logic [N_SEL-1:0][SEL_W-1:0]    sel
);
    typedef struct packed {
        logic [N_SEL-1:0][SEL_W-1:0] fld;
    } regs_t;

    regs_t st_d, st_q;
    int    even_idx;

    assign even_idx = int'(addr) * 2;

    // Next-state: a write replaces both fields of the addressed word
    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.fld[even_idx]     = wdata[XB_LO_OFF +: SEL_W];
            st_d.fld[even_idx + 1] = wdata[XB_HI_OFF +: SEL_W];
        end
    end

    // Each field resets to its selector number (line index plus one)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < N_SEL; n++) begin
                st_q.fld[n] <= SEL_W'(n + 1);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // Reserved bits read back as zero
    always_comb begin
        rdata = '0;
        rdata[XB_LO_OFF +: SEL_W] = st_q.fld[even_idx];
        rdata[XB_HI_OFF +: SEL_W] = st_q.fld[even_idx + 1];
    end

    assign sel = st_q.fld;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[XB_HI_OFF-1:XB_LO_OFF+SEL_W],
                            wdata[XB_WORD_W-1:XB_HI_OFF+SEL_W]};
endmodule

// File: rtl/xbar_pick.sv
`timescale 1ns/1ps
module xbar_pick #(
    parameter int N_IN  = 420,
    parameter int SEL_W = 9
) (
    input  logic [N_IN-1:0]  vec,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    // Index 0 and indices past the vector end select nothing
    always_comb begin
        hit = 1'b0;
        if (sel != '0 && int'(sel) < N_IN) begin
            hit = vec[sel];
        end
    end
endmodule

// File: rtl/xbar_outstage.sv
`timescale 1ns/1ps
module xbar_outstage #(
    parameter int N_OUT   = 32,
    parameter bit REG_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] raw,
    output logic [N_OUT-1:0] out
);
    if (REG_OUT) begin : g_reg
        logic [N_OUT-1:0] out_d, out_q;

        always_comb begin
            out_d = raw;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end

        assign out = out_q;
    end else begin : g_comb
        assign out = raw;
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
    end
endmodule

// File: rtl/irq_xbar_top.sv
`timescale 1ns/1ps
module irq_xbar_top
    import irq_xbar_pkg::*;
#(
    parameter int N_IN    = 420,
    parameter int N_OUT   = 32,
    parameter int N_SEL   = 8,
    parameter int SEL_W   = XB_SEL_W,
    parameter int EXT_IDX = 2,
    parameter bit REG_OUT = 1'b0,
    parameter logic [N_OUT-N_SEL-1:0] FIXED_MASK = 'h100202,
    localparam int N_FIX  = N_OUT - N_SEL,
    localparam int ADDR_W = $clog2(N_SEL / 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_IN-1:0]      dev_irq,
    input  logic                 ext_irq_n,
    input  logic [N_FIX-1:0]     fixed_irq,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [XB_WORD_W-1:0] reg_wdata,
    output logic [XB_WORD_W-1:0] reg_rdata,
    output logic [N_OUT-1:0]     irq_out
);
    logic [N_SEL-1:0][SEL_W-1:0] sel_bus;
    logic [N_IN-1:0]             eff_irq;
    logic [N_OUT-1:0]            raw_irq;

    xbar_regs #(
        .N_SEL (N_SEL),
        .SEL_W (SEL_W),
        .ADDR_W(ADDR_W)
    ) regs_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .rdata(reg_rdata),
        .sel  (sel_bus)
    );

    // The external pin is active low; present it active high
    always_comb begin
        eff_irq          = dev_irq;
        eff_irq[EXT_IDX] = ~ext_irq_n;
    end

    for (genvar n = 0; n < N_SEL; n++) begin : g_sel
        xbar_pick #(
            .N_IN (N_IN),
            .SEL_W(SEL_W)
        ) pick_i (
            .vec(eff_irq),
            .sel(sel_bus[n]),
            .hit(raw_irq[n])
        );
    end

    // Hardwired upper lines
    assign raw_irq[N_OUT-1:N_SEL] = fixed_irq & FIXED_MASK;

    xbar_outstage #(
        .N_OUT  (N_OUT),
        .REG_OUT(REG_OUT)
    ) out_i (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_irq),
        .out  (irq_out)
    );
endmodule

// File: rtl/xbar_chk.sv
`timescale 1ns/1ps
module xbar_chk
    import irq_xbar_pkg::*;
#(
    parameter int N_IN    = 420,
    parameter int N_OUT   = 32,
    parameter int N_SEL   = 8,
    parameter int SEL_W   = 9,
    parameter bit REG_OUT = 1'b0,
    parameter logic [N_OUT-N_SEL-1:0] FIXED_MASK = 'h100202,
    parameter int ADDR_W  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [XB_WORD_W-1:0]        reg_wdata,
    input logic [XB_WORD_W-1:0]        reg_rdata,
    input logic [N_OUT-1:0]            irq_out,
    input logic [N_OUT-N_SEL-1:0]      fixed_irq,
    input logic [N_SEL-1:0][SEL_W-1:0] sel_bus
);
    function automatic logic [XB_WORD_W-1:0] dflt_word(input logic [ADDR_W-1:0] a);
        logic [XB_WORD_W-1:0] w;
        w = '0;
        w[XB_LO_OFF +: SEL_W] = SEL_W'(int'(a) * 2 + 1);
        w[XB_HI_OFF +: SEL_W] = SEL_W'(int'(a) * 2 + 2);
        return w;
    endfunction

    // R4
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~XB_FIELD_MASK) == '0);

    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> reg_rdata == dflt_word(reg_addr));

    // R5
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we) && $past(rst_n) && reg_addr == $past(reg_addr))
        |-> reg_rdata == ($past(reg_wdata) & XB_FIELD_MASK));

    if (!REG_OUT) begin : g_comb_chk
        for (genvar n = 0; n < N_SEL; n++) begin : g_line
            // R3
            oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_bus[n] == '0 || int'(sel_bus[n]) >= N_IN) |-> !irq_out[n]);
        end
        // R7
        fixed_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[N_OUT-1:N_SEL] == (fixed_irq & FIXED_MASK));
    end else begin : g_reg_chk
        // R8
        fixed_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> irq_out[N_OUT-1:N_SEL] == $past(fixed_irq & FIXED_MASK));
    end
endmodule

bind irq_xbar_top xbar_chk #(
    .N_IN      (N_IN),
    .N_OUT     (N_OUT),
    .N_SEL     (N_SEL),
    .SEL_W     (SEL_W),
    .REG_OUT   (REG_OUT),
    .FIXED_MASK(FIXED_MASK),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_out  (irq_out),
    .fixed_irq(fixed_irq),
    .sel_bus  (sel_bus)
);

// File: tb/irq_xbar_top_tb_top.sv
`timescale 1ns/1ps
module irq_xbar_top_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n;
    logic [419:0] dev_irq;
    logic         ext_irq_n;
    logic [23:0]  fixed_irq;
    logic         reg_we;
    logic [1:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata, rdata_r;
    logic [31:0]  irq_out, irq_out_r;

    irq_xbar_top dut_i (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .ext_irq_n(ext_irq_n),
        .fixed_irq(fixed_irq), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    irq_xbar_top #(.REG_OUT(1'b1)) dut_r_i (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .ext_irq_n(ext_irq_n),
        .fixed_irq(fixed_irq), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_r), .irq_out(irq_out_r)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    // Monitor: compare pending items shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                case (it.kind)
                    0:       chk(it.tag, irq_out, it.exp);
                    1:       chk(it.tag, reg_rdata, it.exp);
                    default: chk(it.tag, irq_out_r, it.exp);
                endcase
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        dev_irq   = '0;
        ext_irq_n = 1'b1;
        fixed_irq = '0;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        repeat (3) @(negedge clk);
        push(0, 32'h0, "R1 outputs idle in reset");
        push(2, 32'h0, "R8 registered output reset");
        step();
        rst_n = 1'b1;
        step();

        // R1: default fields for every word
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            push(1, {7'b0, 9'(2 * a + 2), 7'b0, 9'(2 * a + 1)}, "R1 reset field values");
            step();
        end

        // R2/R6/R8: default routing, external pin low
        for (int s = 1; s <= 8; s++) dev_irq[s] = 1'b1;
        dev_irq[2] = 1'b0;
        ext_irq_n  = 1'b0;
        #1 chk("R8 registered output still old", irq_out_r, 32'h0);
        push(0, 32'h0000_00FF, "R2 default routing");
        push(2, 32'h0000_00FF, "R8 registered output one cycle later");
        step();

        // R6: pin high drops line 1; dev_irq[2] and dev_irq[0] have no effect
        ext_irq_n  = 1'b1;
        dev_irq[2] = 1'b1;
        dev_irq[0] = 1'b1;
        push(0, 32'h0000_00FD, "R6 external pin polarity and ignored bits");
        step();

        // R5: write visible only after the edge
        reg_addr  = 2'd0;
        reg_wdata = {7'h7F, 9'd100, 7'h7F, 9'd419};
        reg_we    = 1'b1;
        #1 chk("R5 read before write edge", reg_rdata, 32'h0002_0001);
        @(negedge clk);
        reg_we = 1'b0;
        push(1, 32'h0064_01A3, "R5 packed field readback");
        step();

        // R2: arbitrary selects
        dev_irq = '0;
        dev_irq[419] = 1'b1;
        push(0, 32'h0000_0001, "R2 select 419");
        step();
        dev_irq[100] = 1'b1;
        push(0, 32'h0000_0003, "R2 select 100 on odd line");
        step();

        // R3/R4: out-of-range selects and reserved bits
        wr(2'd1, {7'b0, 9'd420, 7'b0, 9'd0});
        wr(2'd2, 32'hFFFF_FFFF);
        dev_irq   = '1;
        ext_irq_n = 1'b0;
        push(0, 32'h0000_00C3, "R3 index 0, 420 and 511 give zero");
        step();
        reg_addr = 2'd1;
        push(1, 32'h01A4_0000, "R5 readback word 1");
        step();
        reg_addr = 2'd2;
        push(1, 32'h01FF_01FF, "R4 reserved bits read zero");
        step();

        // R7: fixed upper lines
        fixed_irq = '1;
        push(0, 32'h1002_02C3, "R7 fixed lines masked");
        step();
        wr(2'd3, 32'h0000_0000);
        push(0, 32'h1002_0203, "R7 fixed lines unchanged by write");
        step();
        fixed_irq = '0;
        push(0, 32'h0000_0003, "R7 fixed lines follow sources");
        step();
        step();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule